// File: doc/BRIEF.md
# Register-Mapped Two-Stage Watchdog Timer

This block is a watchdog that software drives through a small byte-addressed register window. A synchronous single-cycle read/write port reaches that window. A prescaler divides the system clock into a slow tick, nominally 0.6 s. On each tick a countdown steps down by one. The countdown is loaded from a programmable initial-value register. Software keeps the system alive by writing anything to the reload offset before the count runs out. It can also freeze the countdown with a halt bit, read back the live count, and clear the timeout flags.

Expiry works in two stages. The first time the count runs out, the block reloads it and raises a first-timeout flag. If the count runs out again while that flag is still set, the block raises a second-timeout flag and sends a one-cycle reset request to the system reset logic. A no-reboot input can hold that request back; the block keeps counting and still records the event. The parameter `GEN` selects a narrow generation (6-bit count, 8-bit initial-value register at offset 0x01) or a wide generation (10-bit count, 16-bit initial-value register at offset 0x12).

Top module: `wdog_regwin`

## Requirements
- R1: After reset the halt bit is 1, the initial-value field is 4, the count is 4, all flags are clear and `reboot_req` is 0.
- R2: While halt is 0, the count drops by one on every tick, and a tick occurs once every `TICK_DIV` clock cycles counted from the release of reset.
- R3: Bit 11 of the control word at offset 0x08 is the halt bit. At 1 it freezes the count; at 0 the count runs. It reads back as written, and the other bits of that word read 0.
- R4: Any write to offset 0x00 loads the count from the initial-value field. A read of 0x00 returns the count in its low 6 bits (GEN=1) or low 10 bits (GEN=2), with zeros above.
- R5: The initial-value register sits at 0x01 (GEN=1, 8 bits, field in bits 5:0) or at 0x12 (GEN=2, 16 bits, field in bits 9:0). The bits above the field are stored as written and read back. The offset of the other generation reads 0 and ignores writes.
- R6: A write whose field value is 0, 1, 2 or 3 leaves the stored field unchanged. The upper bits of that write are still stored.
- R7: A running tick that finds the count at 0 reloads the count from the initial-value field. If status bit 3 at offset 0x04 is clear, that tick sets it.
- R8: A running tick that finds the count at 0 while bit 3 of 0x04 is already set sets bit 1 of the status word at 0x06. In the next cycle `reboot_req` is 1 for exactly one cycle, unless `no_reboot` was high.
- R9: If `no_reboot` is high at such a second expiry, `reboot_req` stays 0. Bit 1 of 0x06 is set as usual, and bit 0 of 0x06 is set as well to record the blocked request.
- R10: The status bits are write-one-to-clear. A 0 written to a flag bit has no effect, writing 3 to 0x06 clears both of its flags, and a flag set in the same cycle as its clear stays set.
- R11: A reload write in the same cycle as a tick wins: the count is loaded, not decremented, and no expiry is taken.
- R12: Read data is registered. It appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read. Offsets other than those listed above, including 0x0A, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 5 | Byte offset within the register window |
| bus_wdata | input | 16 | Write data |
| no_reboot | input | 1 | Holds back the reset request when high |
| bus_rdata | output | 16 | Registered read data |
| reboot_req | output | 1 | One-cycle reset request after a second timeout |

## Verification
The bench writes every initial-value code of both generations. It catches a design that accepts values below the floor, drops the stored upper bits, or answers on the other generation's offset. It places reload writes on every prescaler phase, so a design that lets a coinciding tick decrement, or that takes an expiry, shows a count one step off. It lets the timer expire twice, with and without `no_reboot`. A design that pulses the reset while inhibited, fails to record the blocked request, or treats status writes of 0 as clears shows up at once on the reads of 0x04 and 0x06. Frozen-count reads while halted reveal a halt bit in the wrong position or one that leaks ticks.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int unsigned WIN_AW = 5;
  localparam int unsigned BUS_DW = 16;

  localparam logic [WIN_AW-1:0] A_RELOAD      = 5'h00;
  localparam logic [WIN_AW-1:0] A_INIT_NARROW = 5'h01;
  localparam logic [WIN_AW-1:0] A_STS1        = 5'h04;
  localparam logic [WIN_AW-1:0] A_STS2        = 5'h06;
  localparam logic [WIN_AW-1:0] A_CTL1        = 5'h08;
  localparam logic [WIN_AW-1:0] A_INIT_WIDE   = 5'h12;

  localparam int unsigned HALT_POS   = 11;
  localparam int unsigned TO1_POS    = 3;
  localparam int unsigned TO2_POS    = 1;
  localparam int unsigned BLK_POS    = 0;
  localparam int unsigned INIT_FLOOR = 4;

  function automatic int unsigned field_w(int unsigned gen);
    return (gen == 1) ? 6 : 10;
  endfunction

  function automatic int unsigned ireg_w(int unsigned gen);
    return (gen == 1) ? 8 : 16;
  endfunction

  typedef enum logic [1:0] {EXP_NONE, EXP_FIRST, EXP_SECOND} expiry_e;
endpackage

// File: rtl/wdog_prescale.sv
`timescale 1ns/1ps
module wdog_prescale #(
  parameter int unsigned DIV = 30_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick_o = (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)         phase_q <= '0;
    else if (tick_o) phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_spacing
      // R2: ticks are isolated single-cycle strobes
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/wdog_countdown.sv
`timescale 1ns/1ps
module wdog_countdown #(
  parameter int unsigned CW      = 10,
  parameter int unsigned RST_VAL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          halt_i,
  input  logic          reload_i,
  input  logic [CW-1:0] init_i,
  output logic [CW-1:0] count_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          run;

  assign run      = tick_i && !halt_i && !reload_i;
  assign expire_o = run && (cnt_q == '0);
  assign count_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= CW'(RST_VAL);
    else if (reload_i || expire_o)  cnt_q <= init_i;
    else if (run)                   cnt_q <= cnt_q - 1'b1;
  end

  // R11: a reload write always lands the initial value
  a_r11_reload_wins: assert property (@(posedge clk) disable iff (rst)
    reload_i |=> (count_o == $past(init_i)));
  // R3: halted count does not move without a reload
  a_r3_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    (halt_i && !reload_i) |=> $stable(count_o));
  // R2: a running tick on a nonzero count steps down by one
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !halt_i && !reload_i && (count_o != '0)) |=> (count_o == $past(count_o) - 1'b1));
endmodule

// File: rtl/wdog_regfile.sv
`timescale 1ns/1ps
module wdog_regfile
  import wdog_pkg::*;
#(
  parameter int unsigned GEN = 2,
  parameter int unsigned CW  = field_w(GEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [WIN_AW-1:0] addr_i,
  input  logic [BUS_DW-1:0] wdata_i,
  input  logic              no_reboot_i,
  input  logic [CW-1:0]     count_i,
  input  logic              expire_i,
  output logic              reload_o,
  output logic              halt_o,
  output logic [CW-1:0]     init_o,
  output logic [BUS_DW-1:0] rdata_o,
  output logic              reboot_o
);
  localparam int unsigned IW = ireg_w(GEN);
  localparam int unsigned HW = IW - CW;
  localparam logic [WIN_AW-1:0] A_INIT = (GEN == 1) ? A_INIT_NARROW : A_INIT_WIDE;

  logic [CW-1:0]     init_q;
  logic [HW-1:0]     init_hi_q;
  logic              halt_q, to1_q, to2_q, blk_q, reboot_q;
  logic [BUS_DW-1:0] rdata_q, rd_mux;
  logic              wr_init, wr_ctl1, wr_sts1, wr_sts2;
  logic [CW-1:0]     wr_field;
  logic              wr_field_ok;
  expiry_e           ev;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  assign reload_o    = wr_i && (addr_i == A_RELOAD);
  assign wr_init     = wr_i && (addr_i == A_INIT);
  assign wr_ctl1     = wr_i && (addr_i == A_CTL1);
  assign wr_sts1     = wr_i && (addr_i == A_STS1);
  assign wr_sts2     = wr_i && (addr_i == A_STS2);
  assign wr_field    = wdata_i[CW-1:0];
  assign wr_field_ok = (wr_field >= CW'(INIT_FLOOR));

  always_comb begin
    if (!expire_i)  ev = EXP_NONE;
    else if (to1_q) ev = EXP_SECOND;
    else            ev = EXP_FIRST;
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_RELOAD: rd_mux[CW-1:0]  = count_i;
      A_INIT:   rd_mux[IW-1:0]  = {init_hi_q, init_q};
      A_STS1:   rd_mux[TO1_POS] = to1_q;
      A_STS2: begin
        rd_mux[TO2_POS] = to2_q;
        rd_mux[BLK_POS] = blk_q;
      end
      A_CTL1:   rd_mux[HALT_POS] = halt_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q    <= CW'(INIT_FLOOR);
      init_hi_q <= '0;
      halt_q    <= 1'b1;
      to1_q     <= 1'b0;
      to2_q     <= 1'b0;
      blk_q     <= 1'b0;
      reboot_q  <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (wr_init) begin
        init_hi_q <= wdata_i[IW-1:CW];
        if (wr_field_ok) init_q <= wr_field;
      end
      if (wr_ctl1) halt_q <= wdata_i[HALT_POS];

      if (ev == EXP_FIRST)                   to1_q <= 1'b1;
      else if (wr_sts1 && wdata_i[TO1_POS])  to1_q <= 1'b0;

      if (ev == EXP_SECOND)                  to2_q <= 1'b1;
      else if (wr_sts2 && wdata_i[TO2_POS])  to2_q <= 1'b0;

      if (ev == EXP_SECOND && no_reboot_i)   blk_q <= 1'b1;
      else if (wr_sts2 && wdata_i[BLK_POS])  blk_q <= 1'b0;

      reboot_q <= (ev == EXP_SECOND) && !no_reboot_i;
      if (rd_i) rdata_q <= rd_mux;
    end
  end

  assign halt_o   = halt_q;
  assign init_o   = init_q;
  assign rdata_o  = rdata_q;
  assign reboot_o = reboot_q;

  // R6: field values under the floor never land
  a_r6_floor: assert property (@(posedge clk) disable iff (rst)
    (wr_init && (wdata_i[CW-1:0] < CW'(INIT_FLOOR))) |=> (init_o == $past(init_o)));
  // R7: a first expiry raises the first-stage flag
  a_r7_first_flag: assert property (@(posedge clk) disable iff (rst)
    (expire_i && !to1_q) |=> to1_q);
  // R8: the reset request is a single-cycle pulse
  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    reboot_o |=> !reboot_o);
  // R9: no request leaves while inhibited
  a_r9_inhibit: assert property (@(posedge clk) disable iff (rst)
    reboot_o |-> !$past(no_reboot_i));
  // R8: request only follows a second-stage expiry
  a_r8_second_only: assert property (@(posedge clk) disable iff (rst)
    reboot_o |-> to2_q);
endmodule

// File: rtl/wdog_regwin.sv
`timescale 1ns/1ps
module wdog_regwin
  import wdog_pkg::*;
#(
  parameter int unsigned GEN      = 2,
  parameter int unsigned TICK_DIV = 30_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic        no_reboot,
  output logic [15:0] bus_rdata,
  output logic        reboot_req
);
  localparam int unsigned CW = field_w(GEN);

  logic          tick, halt, reload, expire;
  logic [CW-1:0] init_val, count;

  wdog_prescale #(.DIV(TICK_DIV)) u_prescale (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  wdog_countdown #(.CW(CW), .RST_VAL(INIT_FLOOR)) u_countdown (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .halt_i   (halt),
    .reload_i (reload),
    .init_i   (init_val),
    .count_o  (count),
    .expire_o (expire)
  );

  wdog_regfile #(.GEN(GEN), .CW(CW)) u_regfile (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (bus_wr),
    .rd_i        (bus_rd),
    .addr_i      (bus_addr),
    .wdata_i     (bus_wdata),
    .no_reboot_i (no_reboot),
    .count_i     (count),
    .expire_i    (expire),
    .reload_o    (reload),
    .halt_o      (halt),
    .init_o      (init_val),
    .rdata_o     (bus_rdata),
    .reboot_o    (reboot_req)
  );
endmodule

// File: tb/test_wdog_regwin.sv
`timescale 1ns/1ps
module wdog_ref #(
  parameter int GEN = 2,
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic        rd,
  input  logic [4:0]  addr,
  input  logic [15:0] wdata,
  input  logic        nrb,
  output logic [15:0] exp_rdata,
  output logic        exp_rr
);
  localparam int FM   = (GEN == 1) ? 64 : 1024;
  localparam int HM   = (GEN == 1) ? 4 : 64;
  localparam int IOFS = (GEN == 1) ? 1 : 18;

  int pc, cnt, ini, hi, halt, f1, f2, fb;

  function automatic int rdv(int a);
    if (a == 0)    return cnt;
    if (a == IOFS) return ini + hi * FM;
    if (a == 4)    return f1 * 8;
    if (a == 6)    return f2 * 2 + fb;
    if (a == 8)    return halt * 2048;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      pc = 0; cnt = 4; ini = 4; hi = 0; halt = 1;
      f1 = 0; f2 = 0; fb = 0; exp_rr = 0; exp_rdata = 0;
    end else begin
      int tick, ev, p1, w, a;
      w = int'(wdata); a = int'(addr);
      if (rd) exp_rdata = 16'(rdv(a));
      tick = (pc == DIV - 1) ? 1 : 0;
      pc = (pc + 1) % DIV;
      ev = 0;
      if (wr && a == 0) cnt = ini;
      else if (tick == 1 && halt == 0) begin
        if (cnt == 0) begin cnt = ini; ev = 1; end
        else cnt = cnt - 1;
      end
      p1 = f1;
      exp_rr = 0;
      if (wr && a == 4 && w[3]) f1 = 0;
      if (wr && a == 6 && w[1]) f2 = 0;
      if (wr && a == 6 && w[0]) fb = 0;
      if (ev == 1) begin
        if (p1 == 1) begin
          f2 = 1;
          if (nrb) fb = 1; else exp_rr = 1;
        end else f1 = 1;
      end
      if (wr && a == IOFS) begin
        hi = (w / FM) % HM;
        if (w % FM >= 4) ini = w % FM;
      end
      if (wr && a == 8) halt = (w >> 11) & 1;
    end
  end
endmodule

module test_wdog_regwin;
  localparam int DIV = 4;

  logic        clk = 0, rst = 1;
  logic        bus_wr = 0, bus_rd = 0, no_reboot = 0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] d1_rdata, d2_rdata, m1_rdata, m2_rdata;
  logic        d1_rr, d2_rr, m1_rr, m2_rr;
  int compared = 0, mismatched = 0;
  int inhib_bad = 0, pulses = 0;

  always #10 clk = ~clk;

  wdog_regwin #(.GEN(1), .TICK_DIV(DIV)) i_wdog_regwin_g1 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .no_reboot(no_reboot), .bus_rdata(d1_rdata), .reboot_req(d1_rr));
  wdog_regwin #(.GEN(2), .TICK_DIV(DIV)) i_wdog_regwin (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .no_reboot(no_reboot), .bus_rdata(d2_rdata), .reboot_req(d2_rr));
  wdog_ref #(.GEN(1), .DIV(DIV)) u_ref1 (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
    .nrb(no_reboot), .exp_rdata(m1_rdata), .exp_rr(m1_rr));
  wdog_ref #(.GEN(2), .DIV(DIV)) u_ref2 (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
    .nrb(no_reboot), .exp_rdata(m2_rdata), .exp_rr(m2_rr));

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    chk({tag, " gen1"}, int'(d1_rdata), int'(m1_rdata));
    chk({tag, " gen2"}, int'(d2_rdata), int'(m2_rdata));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R8 / R9: reset request compared every cycle it is expected or seen
  always @(negedge clk) begin
    if (!rst) begin
      if (d1_rr || m1_rr) chk("R8 reboot gen1", int'(d1_rr), int'(m1_rr));
      if (d2_rr || m2_rr) chk("R8 reboot gen2", int'(d2_rr), int'(m2_rr));
      if (d1_rr || d2_rr) pulses++;
      if (no_reboot && (d1_rr || d2_rr)) inhib_bad++;
    end
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset state
    chk("R1 reboot idle", int'(d1_rr | d2_rr), 0);
    rd(5'h00, "R1 count");
    rd(5'h01, "R1 narrow init");
    rd(5'h12, "R1 wide init");
    rd(5'h08, "R1 halt");
    rd(5'h04, "R1 sts1");
    rd(5'h06, "R1 sts2");

    // R5 / R6: sweep every initial-value code of both generations
    for (int v = 0; v < 1024; v++) begin
      wr(5'h12, 16'(v | (((v * 7) % 64) << 10)));
      rd(5'h12, (v < 4) ? "R6 wide floor" : "R5 wide init");
    end
    for (int v = 0; v < 256; v++) begin
      wr(5'h01, 16'(v | (v << 8)));
      rd(5'h01, ((v % 64) < 4) ? "R6 narrow floor" : "R5 narrow init");
    end
    rd(5'h12, "R5 cross offset");

    // R4: reload from initial value
    wr(5'h01, 16'd5);
    wr(5'h12, 16'd5);
    wr(5'h00, 16'h00A5);
    rd(5'h00, "R4 reload");

    // R2 / R7 / R8: run freely through two expiries
    pulses = 0;
    wr(5'h08, 16'h0000);
    for (int i = 0; i < 60; i++) begin
      rd(5'h00, "R2 count");
      idle(i % 3);
      if (i % 10 == 9) begin
        rd(5'h04, "R7 sts1");
        rd(5'h06, "R8 sts2");
      end
    end
    chk("R8 pulse seen", int'(pulses > 0), 1);

    // R10: write-one-to-clear
    wr(5'h04, 16'h0000);
    rd(5'h04, "R10 zero write");
    wr(5'h04, 16'h0008);
    rd(5'h04, "R10 clear sts1");
    wr(5'h06, 16'h0003);
    rd(5'h06, "R10 clear sts2");

    // R9: inhibited second expiry
    no_reboot = 1;
    for (int i = 0; i < 40; i++) begin
      rd(5'h06, "R9 sts2");
      idle(1);
    end
    rd(5'h04, "R9 sts1");
    no_reboot = 0;
    chk("R9 no pulse while inhibited", inhib_bad, 0);
    wr(5'h06, 16'h0001);
    rd(5'h06, "R10 clear blocked bit");
    wr(5'h06, 16'h0003);
    wr(5'h04, 16'h0008);

    // R11: reload on every prescaler phase
    for (int p = 0; p < 2 * DIV; p++) begin
      idle(p % DIV);
      wr(5'h00, 16'h0000);
      rd(5'h00, "R11 reload phase");
      rd(5'h00, "R11 after reload");
    end

    // R3: halt freezes the count, bit 11 only
    wr(5'h08, 16'hFFFF);
    rd(5'h08, "R3 halt readback");
    rd(5'h00, "R3 frozen a");
    idle(3 * DIV + 1);
    rd(5'h00, "R3 frozen b");
    wr(5'h08, 16'h0000);
    rd(5'h08, "R3 run readback");
    idle(2 * DIV);
    rd(5'h00, "R3 running");

    // R12: unmapped offsets and registered read data
    rd(5'h0A, "R12 unmapped 0A");
    rd(5'h1F, "R12 unmapped 1F");
    idle(2);
    chk("R12 hold gen2", int'(d2_rdata), int'(m2_rdata));

    finish_run();
  end
endmodule